// File: doc/BRIEF.md
# Virtual Tile Edge Color Hasher

This block sits in front of a texture unit that builds a large virtual texture out of a small, fully populated set of square tiles. Each tile edge carries a color, and two tiles may only sit next to each other when the edge they share has the same color on both sides. For one texture coordinate pair, the block works out which virtual tile the coordinate lands in, where inside that tile it falls, and the four edge colors of that tile. A later stage uses the colors to pick the stored tile.

The colors come from chained lookups into a small permutation table. No map of the whole virtual texture is stored. Any tile can be computed on its own, and neighbouring tiles still agree on the edges they share. The table is a single-port RAM. Software fills it through a write port before use. One request at a time is taken through a valid/ready handshake. Its table reads go through the one port in sequence, and the result comes back as a one-cycle valid pulse.

Coordinates are unsigned fractions of FRAC_W bits in [0, 1). Any integer part is dropped by the caller, because the tiling wraps around. The tile counts Mh = 2^LOG_MH and Mv = 2^LOG_MV and the color counts Kh = 2^LOG_KH and Kv = 2^LOG_KV are powers of two. The table holds max(Mh, Mv) entries.

Top module: `tile_edge_hasher`

## Requirements
- R1: The tile index on each axis is floor(coord × M) mod M, with Mh = 8 on the horizontal axis and Mv = 4 on the vertical axis by default. For 12-bit coordinates this is s[11:9] and t[11:10].
- R2: The offset inside the tile on each axis is the fractional part of coord × M, given as a FRAC_W-bit fraction. By default this is {s[8:0],3'b0} and {t[9:0],2'b0}.
- R3: With H[] the table and indices taken modulo the table size, the south color is H[H[x] + y] mod Kh and the north color is H[H[x] + (y+1) mod Mv] mod Kh. The color is the low LOG_KH bits of the entry.
- R4: The west color is H[x + H[2y]] mod Kv and the east color is H[(x+1) mod Mh + H[2y]] mod Kv. The color is the low LOG_KV bits of the entry.
- R5: The east color of tile (x, y) equals the west color of tile ((x+1) mod Mh, y). The north color of tile (x, y) equals the south color of tile (x, (y+1) mod Mv).
- R6: The table has max(Mh, Mv) entries. A write with tbl_we high stores tbl_data at tbl_addr. Requests made after the write use the new contents.
- R7: in_ready is high when the block is idle. A request is taken at a clock edge where in_valid and in_ready are both high. From the next cycle, in_ready stays low until the cycle in which the result appears. A request offered while in_ready is low is not taken and produces no result.
- R8: When no table write overlaps the lookup, out_valid is high for exactly one cycle, after the 7th rising edge following the edge that took the request. The result outputs hold their values until the next result.
- R9: A table write takes the single table port. Each cycle in which a write meets a pending table read delays the result by one cycle. Reads that happen after the write see the written value.
- R10: While reset is asserted, and after it is released, in_ready is 1, out_valid is 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A coordinate request is offered |
| in_ready | output | 1 | The block can take a request |
| in_s | input | FRAC_W | Horizontal coordinate, unsigned fraction |
| in_t | input | FRAC_W | Vertical coordinate, unsigned fraction |
| tbl_we | input | 1 | Write strobe for the permutation table |
| tbl_addr | input | TBL_AW | Table entry to write |
| tbl_data | input | TBL_AW | Value to write |
| out_valid | output | 1 | One-cycle result pulse |
| out_tile_h | output | LOG_MH | Horizontal tile index |
| out_tile_v | output | LOG_MV | Vertical tile index |
| out_off_h | output | FRAC_W | Horizontal offset inside the tile |
| out_off_v | output | FRAC_W | Vertical offset inside the tile |
| out_south | output | LOG_KH | South edge color |
| out_north | output | LOG_KH | North edge color |
| out_west | output | LOG_KV | West edge color |
| out_east | output | LOG_KV | East edge color |

## Verification
Two functions can fall in the same cycle: a table write, and a lookup read that the sequencer wants to issue through the same port. The bench provokes this by raising tbl_we in the cycle right after a request is taken, first for one cycle with a new value for the very entry that read is about to fetch, and then for two cycles with unchanged data. The result is judged on two things. Its arrival edge must move back by exactly one cycle per overlapping write. Its colors must match a model that uses the table as it stood after the write.

// File: rtl/tile_hash_pkg.sv
// Shared types and helpers for the tile edge color hasher.
// Assumes: all counts handed to the helpers are small non-negative widths.
package tile_hash_pkg;

    // Lookup sequence, one state per table read plus idle and finish.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_X,
        ST_RD_Y,
        ST_RD_S,
        ST_RD_N,
        ST_RD_W,
        ST_RD_E,
        ST_DONE
    } seq_state_t;

    // Address width of the table: the wider of the two tile-count widths.
    function automatic int tbl_aw(input int log_mh, input int log_mv);
        return (log_mh > log_mv) ? log_mh : log_mv;
    endfunction

endpackage

// File: rtl/tile_perm_ram.sv
// Single-port permutation table with registered read.
// A write wins the port. In a write cycle the read register keeps its value,
// so a stalled reader still finds its earlier data.
// Assumes: the contents are undefined until software writes them.
module tile_perm_ram #(
    parameter int AW = 3,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store a written entry.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Registered read, held during write cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re && !we) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/tile_coord_split.sv
// Splits one fractional coordinate into a tile index and an in-tile offset
// for a power-of-two tile count. Multiplying by the count is a shift.
// Assumes: LOG_M < FRAC_W.
module tile_coord_split #(
    parameter int FRAC_W = 12,
    parameter int LOG_M  = 3
) (
    input  logic [FRAC_W-1:0] coord,
    output logic [LOG_M-1:0]  tile,
    output logic [FRAC_W-1:0] offset
);
    localparam int REM_W = FRAC_W - LOG_M;

    // The top bits are the integer part after scaling, already reduced mod M.
    assign tile   = coord[FRAC_W-1 -: LOG_M];
    // The remaining bits, moved up, form the fractional part after scaling.
    assign offset = {coord[REM_W-1:0], {LOG_M{1'b0}}};
endmodule

// File: rtl/tile_hash_seq.sv
// Runs the six distinct table reads of one request through a single port.
// H[x] and H[2y] are each read once and reused.
// A stall (the port taken by a write) freezes any read state.
// Assumes: the table data width equals its address width, and color widths
// are no wider than that.
module tile_hash_seq
    import tile_hash_pkg::*;
#(
    parameter int LOG_MH = 3,
    parameter int LOG_MV = 2,
    parameter int LOG_KH = 1,
    parameter int LOG_KV = 2,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOG_MH-1:0] x_in,
    input  logic [LOG_MV-1:0] y_in,
    input  logic              stall,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [AW-1:0]     rd_data,
    output logic              busy,
    output logic              fin,
    output logic              res_valid,
    output logic [LOG_MH-1:0] res_x,
    output logic [LOG_MV-1:0] res_y,
    output logic [LOG_KH-1:0] res_s,
    output logic [LOG_KH-1:0] res_n,
    output logic [LOG_KV-1:0] res_w,
    output logic [LOG_KV-1:0] res_e
);
    seq_state_t        state;
    logic [LOG_MH-1:0] x_q;
    logic [LOG_MV-1:0] y_q;
    logic [LOG_MH-1:0] x_nxt;
    logic [LOG_MV-1:0] y_nxt;
    logic [AW-1:0]     hx_q;
    logic [AW-1:0]     hy_q;
    logic [LOG_KH-1:0] cs_q;
    logic [LOG_KH-1:0] cn_q;
    logic [LOG_KV-1:0] cw_q;
    logic              reading;
    logic              advance;

    // Neighbour indices, wrapped by the natural width.
    assign x_nxt = x_q + LOG_MH'(1);
    assign y_nxt = y_q + LOG_MV'(1);

    assign reading = (state != ST_IDLE) && (state != ST_DONE);
    assign advance = !(reading && stall);
    assign rd_en   = reading && !stall;
    assign busy    = (state != ST_IDLE);
    assign fin     = (state == ST_DONE);

    // Address for the read issued in the current state.
    always_comb begin
        unique case (state)
            ST_RD_X: rd_addr = AW'(x_q);
            ST_RD_Y: rd_addr = AW'({y_q, 1'b0});
            ST_RD_S: rd_addr = hx_q + AW'(y_q);
            ST_RD_N: rd_addr = hx_q + AW'(y_nxt);
            ST_RD_W: rd_addr = AW'(x_q) + hy_q;
            ST_RD_E: rd_addr = AW'(x_nxt) + hy_q;
            default: rd_addr = '0;
        endcase
    end

    // State walk: accept, issue reads, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (state == ST_IDLE) begin
            if (start) state <= ST_RD_X;
        end else if (state == ST_DONE) begin
            state <= ST_IDLE;
        end else if (advance) begin
            state <= seq_state_t'(state + 3'd1);
        end
    end

    // Latch the tile index on accept and capture each returning read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            hx_q <= '0;
            hy_q <= '0;
            cs_q <= '0;
            cn_q <= '0;
            cw_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                x_q <= x_in;
                y_q <= y_in;
            end
            if (advance) begin
                case (state)
                    ST_RD_Y: hx_q <= rd_data;
                    ST_RD_S: hy_q <= rd_data;
                    ST_RD_N: cs_q <= rd_data[LOG_KH-1:0];
                    ST_RD_W: cn_q <= rd_data[LOG_KH-1:0];
                    ST_RD_E: cw_q <= rd_data[LOG_KV-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Publish the finished result for one cycle; values hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_x     <= '0;
            res_y     <= '0;
            res_s     <= '0;
            res_n     <= '0;
            res_w     <= '0;
            res_e     <= '0;
        end else begin
            res_valid <= fin;
            if (fin) begin
                res_x <= x_q;
                res_y <= y_q;
                res_s <= cs_q;
                res_n <= cn_q;
                res_w <= cw_q;
                res_e <= rd_data[LOG_KV-1:0];
            end
        end
    end
endmodule

// File: rtl/tile_edge_hasher.sv
// Top of the virtual tile edge color hasher. It splits the coordinates into
// tile and offset, runs the chained table hash through a single-port table,
// and returns the tile, offset and four edge colors with a one-cycle pulse.
// Table writes win the port and stall any pending read.
// Assumes: power-of-two tile and color counts, Kh and Kv at most the table size.
module tile_edge_hasher
    import tile_hash_pkg::*;
#(
    parameter int FRAC_W = 12,
    parameter int LOG_MH = 3,
    parameter int LOG_MV = 2,
    parameter int LOG_KH = 1,
    parameter int LOG_KV = 2,
    localparam int TBL_AW = tbl_aw(LOG_MH, LOG_MV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FRAC_W-1:0] in_s,
    input  logic [FRAC_W-1:0] in_t,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_addr,
    input  logic [TBL_AW-1:0] tbl_data,
    output logic              out_valid,
    output logic [LOG_MH-1:0] out_tile_h,
    output logic [LOG_MV-1:0] out_tile_v,
    output logic [FRAC_W-1:0] out_off_h,
    output logic [FRAC_W-1:0] out_off_v,
    output logic [LOG_KH-1:0] out_south,
    output logic [LOG_KH-1:0] out_north,
    output logic [LOG_KV-1:0] out_west,
    output logic [LOG_KV-1:0] out_east
);
    logic [LOG_MH-1:0] tile_h;
    logic [LOG_MV-1:0] tile_v;
    logic [FRAC_W-1:0] off_h;
    logic [FRAC_W-1:0] off_v;
    logic [FRAC_W-1:0] off_h_q;
    logic [FRAC_W-1:0] off_v_q;
    logic              busy;
    logic              fin;
    logic              accept;
    logic              rd_en;
    logic [TBL_AW-1:0] rd_addr;
    logic [TBL_AW-1:0] rd_data;
    logic [TBL_AW-1:0] ram_addr;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;
    assign ram_addr = tbl_we ? tbl_addr : rd_addr;

    tile_coord_split #(.FRAC_W(FRAC_W), .LOG_M(LOG_MH)) u_split_h (
        .coord  (in_s),
        .tile   (tile_h),
        .offset (off_h)
    );

    tile_coord_split #(.FRAC_W(FRAC_W), .LOG_M(LOG_MV)) u_split_v (
        .coord  (in_t),
        .tile   (tile_v),
        .offset (off_v)
    );

    tile_perm_ram #(.AW(TBL_AW), .DW(TBL_AW)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .re    (rd_en),
        .addr  (ram_addr),
        .wdata (tbl_data),
        .rdata (rd_data)
    );

    tile_hash_seq #(
        .LOG_MH (LOG_MH),
        .LOG_MV (LOG_MV),
        .LOG_KH (LOG_KH),
        .LOG_KV (LOG_KV),
        .AW     (TBL_AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (in_valid),
        .x_in      (tile_h),
        .y_in      (tile_v),
        .stall     (tbl_we),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .fin       (fin),
        .res_valid (out_valid),
        .res_x     (out_tile_h),
        .res_y     (out_tile_v),
        .res_s     (out_south),
        .res_n     (out_north),
        .res_w     (out_west),
        .res_e     (out_east)
    );

    // Keep the offsets of the accepted request while its lookups run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_h_q <= '0;
            off_v_q <= '0;
        end else if (accept) begin
            off_h_q <= off_h;
            off_v_q <= off_v;
        end
    end

    // Publish the offsets together with the colors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_off_h <= '0;
            out_off_v <= '0;
        end else if (fin) begin
            out_off_h <= off_h_q;
            out_off_v <= off_v_q;
        end
    end
endmodule

// File: rtl/tile_edge_hasher_chk.sv
// Property checker for tile_edge_hasher, attached by bind.
// It keeps its own copy of the accepted coordinates and a cycle counter
// since the accept, and relates them to the result ports.
module tile_edge_hasher_chk #(
    parameter int FRAC_W = 12,
    parameter int LOG_MH = 3,
    parameter int LOG_MV = 2,
    parameter int LOG_KH = 1,
    parameter int LOG_KV = 2,
    parameter int TBL_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [FRAC_W-1:0] in_s,
    input logic [FRAC_W-1:0] in_t,
    input logic              tbl_we,
    input logic              out_valid,
    input logic [LOG_MH-1:0] out_tile_h,
    input logic [LOG_MV-1:0] out_tile_v,
    input logic [FRAC_W-1:0] out_off_h,
    input logic [FRAC_W-1:0] out_off_v,
    input logic [LOG_KH-1:0] out_south,
    input logic [LOG_KH-1:0] out_north,
    input logic [LOG_KV-1:0] out_west,
    input logic [LOG_KV-1:0] out_east
);
    logic              pend;
    logic              wr_seen;
    logic [7:0]        cnt;
    logic [FRAC_W-1:0] s_l;
    logic [FRAC_W-1:0] t_l;

    // Track the pending request, its coordinates, its age and any writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            wr_seen <= 1'b0;
            cnt     <= '0;
            s_l     <= '0;
            t_l     <= '0;
        end else if (in_valid && in_ready) begin
            pend    <= 1'b1;
            wr_seen <= 1'b0;
            cnt     <= '0;
            s_l     <= in_s;
            t_l     <= in_t;
        end else begin
            if (out_valid) pend <= 1'b0;
            if (pend && tbl_we) wr_seen <= 1'b1;
            if (pend && cnt != 8'hFF) cnt <= cnt + 8'd1;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !out_valid) |-> !in_ready); // R7
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> in_ready); // R7
    AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pend); // R7
    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R8
    AST_LATENCY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cnt >= 8'd7)); // R9
    AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wr_seen) |-> (cnt == 8'd7)); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_south) && $stable(out_north) &&
                        $stable(out_west) && $stable(out_east) &&
                        $stable(out_tile_h) && $stable(out_off_h))); // R8
    AST_TILE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tile_h == s_l[FRAC_W-1 -: LOG_MH] &&
                       out_tile_v == t_l[FRAC_W-1 -: LOG_MV])); // R1
    AST_TILE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_off_h == {s_l[FRAC_W-LOG_MH-1:0], {LOG_MH{1'b0}}} &&
                       out_off_v == {t_l[FRAC_W-LOG_MV-1:0], {LOG_MV{1'b0}}})); // R2
endmodule

bind tile_edge_hasher tile_edge_hasher_chk #(
    .FRAC_W (FRAC_W),
    .LOG_MH (LOG_MH),
    .LOG_MV (LOG_MV),
    .LOG_KH (LOG_KH),
    .LOG_KV (LOG_KV),
    .TBL_AW (TBL_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_s       (in_s),
    .in_t       (in_t),
    .tbl_we     (tbl_we),
    .out_valid  (out_valid),
    .out_tile_h (out_tile_h),
    .out_tile_v (out_tile_v),
    .out_off_h  (out_off_h),
    .out_off_v  (out_off_v),
    .out_south  (out_south),
    .out_north  (out_north),
    .out_west   (out_west),
    .out_east   (out_east)
);

// File: tb/test_tile_edge_hasher.sv
`timescale 1ns/1ps
// Self-checking bench for tile_edge_hasher with the default parameters
// (12-bit coordinates, 8x4 tiles, Kh = 2, Kv = 4, 8-entry table).
module test_tile_edge_hasher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_s = '0;
    logic [11:0] in_t = '0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [2:0]  tbl_data = '0;
    logic        out_valid;
    logic [2:0]  out_tile_h;
    logic [1:0]  out_tile_v;
    logic [11:0] out_off_h;
    logic [11:0] out_off_v;
    logic [0:0]  out_south;
    logic [0:0]  out_north;
    logic [1:0]  out_west;
    logic [1:0]  out_east;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int acc_cyc = 0;
    int pm [8];

    tile_edge_hasher i_tile_edge_hasher (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_s(in_s), .in_t(in_t), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .out_valid(out_valid), .out_tile_h(out_tile_h),
        .out_tile_v(out_tile_v), .out_off_h(out_off_h), .out_off_v(out_off_v),
        .out_south(out_south), .out_north(out_north), .out_west(out_west),
        .out_east(out_east)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Vector fields: s, t, tile_h, tile_v, off_h, off_v
    typedef struct packed {
        logic [11:0] s;
        logic [11:0] t;
        logic [2:0]  th;
        logic [1:0]  tv;
        logic [11:0] oh;
        logic [11:0] ov;
    } vec_t;

    localparam logic [52:0] VECS [0:7] = '{
        {12'h000, 12'h000, 3'd0, 2'd0, 12'h000, 12'h000},
        {12'h200, 12'hC00, 3'd1, 2'd3, 12'h000, 12'h000},
        {12'hFFF, 12'hBFF, 3'd7, 2'd2, 12'hFF8, 12'hFFC},
        {12'h300, 12'h400, 3'd1, 2'd1, 12'h800, 12'h000},
        {12'hE00, 12'hA00, 3'd7, 2'd2, 12'h000, 12'h800},
        {12'hA55, 12'h155, 3'd5, 2'd0, 12'h2A8, 12'h554},
        {12'hDFF, 12'h7FF, 3'd6, 2'd1, 12'hFF8, 12'hFFC},
        {12'h001, 12'h001, 3'd0, 2'd0, 12'h008, 12'h004}
    };

    function automatic int hv(input int i);
        return pm[i & 7];
    endfunction
    function automatic int m_south(input int x, input int y);
        return hv(hv(x) + y) & 1;
    endfunction
    function automatic int m_north(input int x, input int y);
        return hv(hv(x) + ((y + 1) & 3)) & 1;
    endfunction
    function automatic int m_west(input int x, input int y);
        return hv(x + hv(2 * y)) & 3;
    endfunction
    function automatic int m_east(input int x, input int y);
        return hv(((x + 1) & 7) + hv(2 * y)) & 3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_entry(input int a, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 3'(a); tbl_data = 3'(d);
        @(posedge clk); #1;
        tbl_we = 1'b0;
        pm[a] = d;
    endtask

    task automatic load_table(input int p0, input int p1, input int p2, input int p3,
                              input int p4, input int p5, input int p6, input int p7);
        write_entry(0, p0); write_entry(1, p1); write_entry(2, p2); write_entry(3, p3);
        write_entry(4, p4); write_entry(5, p5); write_entry(6, p6); write_entry(7, p7);
    endtask

    // Offer a request while idle; returns 1 ns after the accepting edge.
    task automatic start_req(input logic [11:0] s, input logic [11:0] t);
        @(negedge clk);
        in_valid = 1'b1; in_s = s; in_t = t;
        @(posedge clk); #1;
        acc_cyc = cyc;
        in_valid = 1'b0;
    endtask

    // Wait for the result pulse; returns latency in edges since acceptance.
    task automatic wait_res(output int lat);
        int guard = 0;
        while (!out_valid && guard < 40) begin
            @(posedge clk); #1;
            guard++;
        end
        lat = out_valid ? (cyc - acc_cyc) : -1;
    endtask

    task automatic check_colors(input int x, input int y, input string tag);
        check(out_south == 1'(m_south(x, y)), {tag, " R3 south"}, out_south, m_south(x, y));
        check(out_north == 1'(m_north(x, y)), {tag, " R3 north"}, out_north, m_north(x, y));
        check(out_west == 2'(m_west(x, y)), {tag, " R4 west"}, out_west, m_west(x, y));
        check(out_east == 2'(m_east(x, y)), {tag, " R4 east"}, out_east, m_east(x, y));
    endtask

    int lat;
    int east_of [8][4];
    int west_of [8][4];
    int south_of [8][4];
    int north_of [8][4];

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        // R10: reset state, during and after reset
        repeat (3) @(posedge clk);
        #1;
        check(in_ready == 1'b1, "R10 in_ready in reset", in_ready, 1);
        check(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(in_ready == 1'b1 && out_valid == 1'b0, "R10 handshake after reset",
              {in_ready, out_valid}, 2'b10);
        check({out_tile_h, out_tile_v, out_off_h, out_off_v, out_south, out_north,
               out_west, out_east} == '0, "R10 outputs zero", out_off_h, 0);

        // R6: load the table
        load_table(5, 2, 7, 0, 3, 6, 1, 4);

        // Vector table walk: R1, R2, R3, R4, R8
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            start_req(v.s, v.t);
            wait_res(lat);
            check(lat == 7, "R8 latency", lat, 7);
            check(out_tile_h == v.th && out_tile_v == v.tv, "R1 tile index",
                  {out_tile_h, out_tile_v}, {v.th, v.tv});
            check(out_off_h == v.oh, "R2 offset h", out_off_h, v.oh);
            check(out_off_v == v.ov, "R2 offset v", out_off_v, v.ov);
            check_colors(int'(v.th), int'(v.tv), "vec");
            @(posedge clk); #1;
            check(out_valid == 1'b0, "R8 single-cycle pulse", out_valid, 0);
        end

        // R8: result holds while idle
        begin
            logic [7:0] snap;
            snap = {out_south, out_north, out_west, out_east, out_tile_v};
            repeat (5) @(posedge clk);
            #1;
            check({out_south, out_north, out_west, out_east, out_tile_v} == snap,
                  "R8 hold", {out_south, out_north, out_west, out_east, out_tile_v}, snap);
        end

        // R5: sweep every tile, then compare neighbouring edges
        for (int y = 0; y < 4; y++) begin
            for (int x = 0; x < 8; x++) begin
                start_req(12'((x << 9) | 12'h0AB), 12'((y << 10) | 12'h013));
                wait_res(lat);
                east_of[x][y]  = int'(out_east);
                west_of[x][y]  = int'(out_west);
                south_of[x][y] = int'(out_south);
                north_of[x][y] = int'(out_north);
            end
        end
        for (int y = 0; y < 4; y++) begin
            for (int x = 0; x < 8; x++) begin
                check(east_of[x][y] == west_of[(x + 1) % 8][y], "R5 east/west match",
                      east_of[x][y], west_of[(x + 1) % 8][y]);
                check(north_of[x][y] == south_of[x][(y + 1) % 4], "R5 north/south match",
                      north_of[x][y], south_of[x][(y + 1) % 4]);
            end
        end

        // R7: requests offered while busy are not taken
        begin
            int pulses = 0;
            start_req(12'h600, 12'h800);   // tile (3,2)
            @(negedge clk);
            in_valid = 1'b1; in_s = 12'h200; in_t = 12'h400;
            for (int k = 0; k < 5; k++) begin
                #1;
                check(in_ready == 1'b0, "R7 busy not ready", in_ready, 0);
                @(negedge clk);
            end
            in_valid = 1'b0;
            wait_res(lat);
            check(out_tile_h == 3'd3 && out_tile_v == 2'd2, "R7 first request kept",
                  {out_tile_h, out_tile_v}, {3'd3, 2'd2});
            check(in_ready == 1'b1, "R7 ready at result", in_ready, 1);
            check_colors(3, 2, "busy");
            for (int k = 0; k < 12; k++) begin
                @(posedge clk); #1;
                if (out_valid) pulses++;
            end
            check(pulses == 0, "R7 busy offer produced no result", pulses, 0);
        end

        // R6: reload a different permutation and rerun
        load_table(3, 6, 1, 4, 7, 2, 5, 0);
        start_req(12'hA55, 12'h155);
        wait_res(lat);
        check_colors(5, 0, "reload R6");

        // R9: write to the entry about to be read, during the read state
        start_req(12'h400, 12'h400);       // tile (2,1); first read is H[2]
        tbl_we = 1'b1; tbl_addr = 3'd2; tbl_data = 3'd6;
        @(posedge clk); #1;
        tbl_we = 1'b0;
        pm[2] = 6;
        wait_res(lat);
        check(lat == 8, "R9 one stall cycle", lat, 8);
        check_colors(2, 1, "stall R9");

        // R9: two write cycles with unchanged data
        start_req(12'hC00, 12'hC00);       // tile (6,3)
        tbl_we = 1'b1; tbl_addr = 3'd0; tbl_data = 3'(pm[0]);
        @(posedge clk); #1;
        @(posedge clk); #1;
        tbl_we = 1'b0;
        wait_res(lat);
        check(lat == 9, "R9 two stall cycles", lat, 9);
        check_colors(6, 3, "stall2 R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule